// File: doc/BRIEF.md
# Low-Power Mode and Wake Controller

This block moves a processor core between normal execution and two power-saving states. In the light state (Idle) only the CPU clock enable is dropped, while peripherals and the main oscillator keep running. In the deep state (Sleep) the CPU clock, the peripheral clock and the main clock source are all turned off. The core enters either state by pulsing a power-save request, with one mode bit selecting which state to enter.

The controller wakes the core for three kinds of event. The first is an enabled interrupt whose priority is above the current CPU priority. The second is a watchdog time-out while the watchdog is enabled. The third is a warm reset. Waking from Idle takes effect on the next clock. Waking from Sleep first turns the oscillator back on and runs a programmable start-up delay. After the delay the oscillator must report stable. If it does not, the controller either keeps waiting or, when the clock monitor is enabled, raises a clock-failure trap and switches to the internal fast RC clock.

Three sticky status flags record that the core left Sleep, left Idle, or was woken by the watchdog. Software clears them with write-one-to-clear strobes. The block's own synchronous reset acts as the power-on reset.

Top module: `lpw_mode_ctrl`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `state_o` is 0 (Run). `cpu_clk_en`, `periph_clk_en` and `osc_run` are 1. All three flags, `frc_sel` and `trap_pulse` are 0.
- R2: State codes are Run=0, Idle=1, Sleep=2, OscWait=3, FailTrap=4. In Run, `save_req` moves the state on the next edge: to Idle when `save_mode`=1, to Sleep when `save_mode`=0. In Idle the outputs are cpu=0, periph=1, osc=1. In Sleep all three are 0.
- R3: `save_req` has no effect in any state other than Run.
- R4: Interrupt source i counts as a wake source only when `irq_pending[i]` and `irq_enable[i]` are both 1 and its 3-bit priority field `irq_prio[3*i+2:3*i]` is strictly greater than `cpu_prio`. In Run, interrupts do not change the state.
- R5: A wake event in Idle returns the state to Run on the next edge, with `cpu_clk_en`=1, and sets `flag_idle`.
- R6: A wake event in Sleep sets `flag_sleep` and enters OscWait. In OscWait the outputs are osc=1, cpu=0, periph=0. The state stays in OscWait for `startup_dly`+1 cycles. If `osc_stable` is 1 at the end of that time, the next state is Run.
- R7: If the start-up delay has expired, `osc_stable` is 0 and `fscm_en`=0, the state stays in OscWait until `osc_stable` rises. Run follows on the next edge.
- R8: If the delay has expired, `osc_stable` is 0 and `fscm_en`=1, the state enters FailTrap for exactly one cycle. During that cycle `trap_pulse`=1 and the CPU clock is enabled. The state then returns to Run with `frc_sel`=1, which stays set until `rst`.
- R9: `wdt_timeout` wakes the core from Idle or Sleep only when `wdt_en`=1. It then sets `flag_wdto` together with the flag of the state being left. With `wdt_en`=0 it has no effect.
- R10: `warm_rst` returns the state to Run on the next edge from any state. It sets `flag_sleep` when leaving Sleep or OscWait, and sets `flag_idle` when leaving Idle. `rst` clears all flags and `frc_sel`.
- R11: `clr_flags` bits clear the flags on the next edge: bit 0 clears sleep, bit 1 clears idle, bit 2 clears wdto. When a flag is set and cleared on the same cycle, it ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| save_req | input | 1 | Power-save request pulse |
| save_mode | input | 1 | 0 = Sleep, 1 = Idle |
| irq_pending | input | N_SRC | Interrupt pending per source |
| irq_enable | input | N_SRC | Interrupt enable per source |
| irq_prio | input | N_SRC*PRIO_W | Packed priority per source |
| cpu_prio | input | PRIO_W | Current CPU priority threshold |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_timeout | input | 1 | Watchdog time-out event |
| warm_rst | input | 1 | Non-power-on reset event |
| osc_stable | input | 1 | Main oscillator reports stable |
| fscm_en | input | 1 | Clock failure monitor enable |
| startup_dly | input | CNT_W | Start-up delay in cycles |
| clr_flags | input | 3 | Write-one-to-clear strobes {wdto, idle, sleep} |
| state_o | output | 3 | Current state code |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Main clock source enable |
| frc_sel | output | 1 | Internal fast RC clock selected |
| trap_pulse | output | 1 | Clock failure trap request |
| flag_sleep | output | 1 | Woke from Sleep |
| flag_idle | output | 1 | Woke from Idle |
| flag_wdto | output | 1 | Woke by watchdog |

## Verification
A wake event that sets a status flag can arrive on the same cycle as a software clear of that flag. The bench provokes this by holding the Idle flag's clear strobe high on the cycle a warm reset leaves Idle. It judges the result by reading `flag_idle` after that edge, which must be 1. A second collision is between the save request and an interrupt while the controller is already in Idle. Here the bench checks that a non-qualifying interrupt neither wakes the core nor lets the request move it to Sleep.

// File: rtl/lpw_pkg.sv
`timescale 1ns/1ps
package lpw_pkg;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_IDLE      = 3'd1,
        ST_SLEEP     = 3'd2,
        ST_OSC_WAIT  = 3'd3,
        ST_FAIL_TRAP = 3'd4
    } pmode_e;

    typedef struct packed {
        logic cpu;
        logic periph;
        logic osc;
    } clk_gate_t;

    // bit 2 wdto, bit 1 idle, bit 0 sleep
    typedef struct packed {
        logic wdto;
        logic idle;
        logic sleep;
    } wake_flags_t;

    function automatic clk_gate_t gates_for(pmode_e s);
        clk_gate_t g;
        case (s)
            ST_IDLE:     g = '{cpu: 1'b0, periph: 1'b1, osc: 1'b1};
            ST_SLEEP:    g = '{cpu: 1'b0, periph: 1'b0, osc: 1'b0};
            ST_OSC_WAIT: g = '{cpu: 1'b0, periph: 1'b0, osc: 1'b1};
            default:     g = '{cpu: 1'b1, periph: 1'b1, osc: 1'b1};
        endcase
        return g;
    endfunction

endpackage

// File: rtl/lpw_irq_match.sv
`timescale 1ns/1ps
module lpw_irq_match #(
    parameter int N_SRC  = 4,
    parameter int PRIO_W = 3
) (
    input  logic [N_SRC-1:0]        pend,
    input  logic [N_SRC-1:0]        en,
    input  logic [N_SRC*PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]       thresh,
    output logic                    hit
);
    logic [N_SRC-1:0] qual;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign qual[i] = pend[i] & en[i] & (prio[i*PRIO_W +: PRIO_W] > thresh);
    end

    assign hit = |qual;
endmodule

// File: rtl/lpw_start_timer.sv
`timescale 1ns/1ps
module lpw_start_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/lpw_flag_bank.sv
`timescale 1ns/1ps
module lpw_flag_bank (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] set_v,
    input  logic [2:0] clr_v,
    output logic [2:0] flags
);
    always_ff @(posedge clk) begin
        if (rst)
            flags <= '0;
        else
            flags <= (flags & ~clr_v) | set_v;
    end
endmodule

// File: rtl/lpw_mode_ctrl.sv
`timescale 1ns/1ps
module lpw_mode_ctrl
    import lpw_pkg::*;
#(
    parameter int N_SRC  = 4,
    parameter int PRIO_W = 3,
    parameter int CNT_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    save_req,
    input  logic                    save_mode,
    input  logic [N_SRC-1:0]        irq_pending,
    input  logic [N_SRC-1:0]        irq_enable,
    input  logic [N_SRC*PRIO_W-1:0] irq_prio,
    input  logic [PRIO_W-1:0]       cpu_prio,
    input  logic                    wdt_en,
    input  logic                    wdt_timeout,
    input  logic                    warm_rst,
    input  logic                    osc_stable,
    input  logic                    fscm_en,
    input  logic [CNT_W-1:0]        startup_dly,
    input  logic [2:0]              clr_flags,
    output logic [2:0]              state_o,
    output logic                    cpu_clk_en,
    output logic                    periph_clk_en,
    output logic                    osc_run,
    output logic                    frc_sel,
    output logic                    trap_pulse,
    output logic                    flag_sleep,
    output logic                    flag_idle,
    output logic                    flag_wdto
);
    pmode_e      state, nxt;
    wake_flags_t set_f;
    logic [2:0]  flags;
    logic        irq_hit, wdt_hit, wake_ev, tmr_load, tmr_done;
    clk_gate_t   gates;

    lpw_irq_match #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_match (
        .pend   (irq_pending),
        .en     (irq_enable),
        .prio   (irq_prio),
        .thresh (cpu_prio),
        .hit    (irq_hit)
    );

    lpw_start_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (startup_dly),
        .run      (state == ST_OSC_WAIT),
        .done     (tmr_done)
    );

    lpw_flag_bank u_flags (
        .clk   (clk),
        .rst   (rst),
        .set_v (set_f),
        .clr_v (clr_flags),
        .flags (flags)
    );

    assign wdt_hit = wdt_en & wdt_timeout;
    assign wake_ev = irq_hit | wdt_hit;

    always_comb begin
        nxt      = state;
        set_f    = '0;
        tmr_load = 1'b0;
        case (state)
            ST_RUN: begin
                if (save_req && !warm_rst)
                    nxt = save_mode ? ST_IDLE : ST_SLEEP;
            end
            ST_IDLE: begin
                if (warm_rst || wake_ev) begin
                    nxt        = ST_RUN;
                    set_f.idle = 1'b1;
                    set_f.wdto = wdt_hit;
                end
            end
            ST_SLEEP: begin
                if (warm_rst) begin
                    nxt         = ST_RUN;
                    set_f.sleep = 1'b1;
                    set_f.wdto  = wdt_hit;
                end else if (wake_ev) begin
                    nxt         = ST_OSC_WAIT;
                    tmr_load    = 1'b1;
                    set_f.sleep = 1'b1;
                    set_f.wdto  = wdt_hit;
                end
            end
            ST_OSC_WAIT: begin
                if (warm_rst) begin
                    nxt         = ST_RUN;
                    set_f.sleep = 1'b1;
                end else if (tmr_done) begin
                    if (osc_stable)
                        nxt = ST_RUN;
                    else if (fscm_en)
                        nxt = ST_FAIL_TRAP;
                end
            end
            ST_FAIL_TRAP: nxt = ST_RUN;
            default:      nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_RUN;
            frc_sel <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_FAIL_TRAP)
                frc_sel <= 1'b1;
        end
    end

    assign gates         = gates_for(state);
    assign cpu_clk_en    = gates.cpu;
    assign periph_clk_en = gates.periph;
    assign osc_run       = gates.osc;
    assign trap_pulse    = (state == ST_FAIL_TRAP);
    assign state_o       = state;
    assign flag_sleep    = flags[0];
    assign flag_idle     = flags[1];
    assign flag_wdto     = flags[2];
endmodule

// File: rtl/lpw_mode_ctrl_chk.sv
`timescale 1ns/1ps
module lpw_mode_ctrl_chk #(
    parameter int N_SRC = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       state_o,
    input logic             cpu_clk_en,
    input logic             periph_clk_en,
    input logic             osc_run,
    input logic             warm_rst,
    input logic             wdt_en,
    input logic             wdt_timeout,
    input logic [N_SRC-1:0] irq_pending,
    input logic [2:0]       clr_flags,
    input logic             trap_pulse,
    input logic             frc_sel,
    input logic             flag_idle
);
    a_r2_idle_gating: assert property (@(posedge clk) disable iff (rst)
        state_o == 3'd1 |-> (!cpu_clk_en && periph_clk_en && osc_run));

    a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd1 && !warm_rst && !wdt_timeout && irq_pending == '0) |=> state_o == 3'd1);

    a_r5_idle_wake: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd1 && warm_rst) |=> (state_o == 3'd0 && cpu_clk_en && flag_idle));

    a_r6_osc_wait_gates: assert property (@(posedge clk) disable iff (rst)
        state_o == 3'd3 |-> (osc_run && !cpu_clk_en && !periph_clk_en));

    a_r8_trap_single: assert property (@(posedge clk) disable iff (rst)
        trap_pulse |=> (!trap_pulse && state_o == 3'd0 && frc_sel));

    a_r9_wdt_disabled: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd2 && wdt_timeout && !wdt_en && !warm_rst && irq_pending == '0)
        |=> state_o == 3'd2);

    a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd1 && warm_rst && clr_flags[1]) |=> flag_idle);
endmodule

bind lpw_mode_ctrl lpw_mode_ctrl_chk #(.N_SRC(N_SRC)) u_chk (.*);

// File: tb/sim_lpw_mode_ctrl.sv
`timescale 1ns/1ps
module sim_lpw_mode_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        save_req = 0, save_mode = 0, wdt_en = 0, wdt_timeout = 0, warm_rst = 0;
    logic        osc_stable = 1, fscm_en = 0;
    logic [3:0]  irq_pending = '0, irq_enable = 4'b0011;
    // src0 prio 5, src1 prio 2, src2 prio 7, src3 prio 6
    logic [11:0] irq_prio = {3'd6, 3'd7, 3'd2, 3'd5};
    logic [2:0]  cpu_prio = 3'd3;
    logic [15:0] startup_dly = '0;
    logic [2:0]  clr_flags = '0;
    logic [2:0]  state_o;
    logic        cpu_clk_en, periph_clk_en, osc_run, frc_sel, trap_pulse;
    logic        flag_sleep, flag_idle, flag_wdto;
    int          checks = 0, failures = 0;
    logic        done = 0;

    always #2.5 clk = ~clk;

    lpw_mode_ctrl u0 (.*);

    // {sreq, smode, wrst, wen, wto, pend[3:0], exp_state[2:0], exp_flags{wdto,idle,sleep}}
    localparam logic [14:0] VEC [14] = '{
        15'b1_1_0_0_0_0000_001_000,  // R2 enter Idle
        15'b1_0_0_0_0_0010_001_000,  // R3 request ignored, R4 low prio
        15'b0_0_0_0_0_0100_001_000,  // R4 disabled source
        15'b0_0_0_0_0_0001_000_010,  // R5 qualifying irq
        15'b1_0_0_0_0_0000_010_010,  // R2 enter Sleep
        15'b0_0_0_0_1_0000_010_010,  // R9 wdt disabled
        15'b0_0_0_1_1_0000_011_111,  // R9 wdt wake
        15'b0_0_0_0_0_0000_000_111,  // R6 zero delay
        15'b1_1_0_0_0_0000_001_111,
        15'b0_0_1_0_0_0000_000_111,  // R10 warm reset from Idle
        15'b1_0_0_0_0_0000_010_111,
        15'b0_0_0_0_0_0001_011_111,  // R6 irq wake Sleep
        15'b0_0_0_0_0_0000_000_111,
        15'b0_0_0_0_0_0001_000_111   // R4 no effect in Run
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        save_req = 0; warm_rst = 0; wdt_timeout = 0; irq_pending = '0; clr_flags = '0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        step(); step();
        check("R1 state", state_o, 0);
        check("R1 gates", {cpu_clk_en, periph_clk_en, osc_run}, 3'b111);
        rst = 0;
        step();
        check("R1 flags", {flag_wdto, flag_idle, flag_sleep, frc_sel, trap_pulse}, 0);

        for (int i = 0; i < 14; i++) begin
            {save_req, save_mode, warm_rst, wdt_en, wdt_timeout, irq_pending} = VEC[i][14:6];
            step();
            check($sformatf("R2-vec%0d state", i), state_o, VEC[i][5:3]);
            check($sformatf("R9-vec%0d flags", i), {flag_wdto, flag_idle, flag_sleep}, VEC[i][2:0]);
        end
        quiet(); wdt_en = 0;

        // R11 clear
        clr_flags = 3'b111; step(); quiet();
        check("R11 clear", {flag_wdto, flag_idle, flag_sleep}, 0);
        // R11 set wins
        save_req = 1; save_mode = 1; step(); quiet();
        check("R2 idle gates", {cpu_clk_en, periph_clk_en, osc_run}, 3'b011);
        warm_rst = 1; clr_flags = 3'b010; step(); quiet();
        check("R11 set wins", flag_idle, 1);
        check("R10 run after warm", state_o, 0);

        // R2 sleep gating, R6 delay
        clr_flags = 3'b111; step(); quiet();
        startup_dly = 16'd4; osc_stable = 1;
        save_req = 1; save_mode = 0; step(); quiet();
        check("R2 sleep gates", {cpu_clk_en, periph_clk_en, osc_run}, 3'b000);
        irq_pending = 4'b0001; step(); quiet();
        check("R6 osc wait gates", {cpu_clk_en, periph_clk_en, osc_run}, 3'b001);
        check("R6 sleep flag", flag_sleep, 1);
        repeat (4) step();
        check("R6 still waiting", state_o, 3);
        step();
        check("R6 run after delay", state_o, 0);

        // R7 hold until stable
        startup_dly = 16'd2; osc_stable = 0; fscm_en = 0;
        save_req = 1; save_mode = 0; step(); quiet();
        irq_pending = 4'b0001; step(); quiet();
        repeat (8) step();
        check("R7 holding", state_o, 3);
        osc_stable = 1; step();
        check("R7 run when stable", state_o, 0);

        // R8 clock fail trap
        startup_dly = 16'd1; osc_stable = 0; fscm_en = 1;
        save_req = 1; save_mode = 0; step(); quiet();
        irq_pending = 4'b0001; step(); quiet();
        step();
        check("R8 pre-trap", {state_o, trap_pulse}, {3'd3, 1'b0});
        step();
        check("R8 trap", {state_o, trap_pulse, cpu_clk_en}, {3'd4, 1'b1, 1'b1});
        step();
        check("R8 after trap", {state_o, trap_pulse, frc_sel}, {3'd0, 1'b0, 1'b1});
        fscm_en = 0; osc_stable = 1;

        // R10 warm reset during OscWait
        clr_flags = 3'b111; step(); quiet();
        startup_dly = 16'd5;
        save_req = 1; save_mode = 0; step(); quiet();
        warm_rst = 1; step(); quiet();
        check("R10 warm from sleep", {state_o, flag_sleep, flag_idle}, {3'd0, 1'b1, 1'b0});
        save_req = 1; save_mode = 0; step(); quiet();
        irq_pending = 4'b0001; step(); quiet();
        check("R6 entered wait", state_o, 3);
        warm_rst = 1; step(); quiet();
        check("R10 warm from osc wait", state_o, 0);

        // R9 watchdog from Idle
        clr_flags = 3'b111; step(); quiet();
        wdt_en = 1;
        save_req = 1; save_mode = 1; step(); quiet();
        wdt_timeout = 1; step(); quiet();
        check("R9 wdt idle wake", {state_o, flag_wdto, flag_idle, flag_sleep}, {3'd0, 3'b110});

        // R10 power-on reset clears
        rst = 1; step(); rst = 0; step();
        check("R10 por clears", {flag_wdto, flag_idle, flag_sleep, frc_sel}, 0);

        done = 1;
        finish_run();
    end
endmodule